// File: doc/BRIEF.md
# Monochrome Passive LCD Timing Generator

This block drives a single-panel monochrome passive LCD through an 8-bit data path. It runs on the memory clock. It makes a pixel-step enable by dividing that clock by a programmable ratio, and all panel timing is counted in these pixel steps (Ts). Each line holds three parts. The first is a line pulse. The next is a display window of shift clocks, and each shift clock moves 8 pixels. Last comes a blanking stretch. The display width and the blanking width are programmed in 8-pixel units, and a fixed overhead of 33 Ts is added to them.

A line counter wraps at a programmed line count. A frame pulse brackets the line pulse of the first line of each frame. A panel polarity signal (MOD) flips once per frame. Pixel bytes enter through a ready/valid stream. Each accepted byte appears on two 4-bit output lanes, upper and lower, for one shift period. The byte changes at the rising edge of the shift clock, which gives 4 Ts of setup and 4 Ts of hold around the falling edge.

Top module: `mono_lcd_timing`

## Requirements
- R1: The pixel step Ts lasts `div_sel`+1 memory clocks (div_sel 0..3 gives divide by 1, 2, 3 or 4). Every state change of the panel timing happens on a pixel step.
- R2: One line lasts L = (hdisp+1)*8 + (hgap+1)*8 + 33 Ts. The pixel-step position h within the line counts 0..L-1 and then returns to 0.
- R3: `lcd_line` is high exactly while h is 0..8 (9 Ts) and low for the rest of the line.
- R4: `lcd_shift` is high when h is inside the display window [16, 16+(hdisp+1)*8) and (h-16) mod 8 < 4. It is low everywhere else, including throughout the line pulse.
- R5: In each 8-Ts slot of the window, the slot byte is driven with bits [7:4] on `lcd_upper` and bits [3:0] on `lcd_lower`. The byte is loaded as the slot opens and held for all 8 Ts. Outside the window both lanes read 0.
- R6: `pix_ready` is high for one memory clock, on the clock whose pixel step opens a slot (h becomes 16+8k). A byte transfers when `pix_valid` is also high. If `pix_valid` is low, that slot shows 0 and no byte is taken.
- R7: The line index counts 0..vlines and then wraps to 0, advancing when h returns to 0. A frame therefore holds vlines+1 lines.
- R8: `lcd_frame` is high from h=23 of the last line (index vlines) through h=22 of line 0. This gives 14 Ts of hold after the line pulse falls and L-14 Ts of setup before it falls.
- R9: `lcd_mod` is 0 after reset. It inverts on the pixel step that brings the last line to h=23, the step on which the frame pulse rises.
- R10: While `rst` is high: h=0 and line index 0, so `lcd_line`=1 and `lcd_frame`=1, while `lcd_shift`=0, `lcd_mod`=0, both lanes are 0 and `pix_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | 2 | Pixel step divider, ratio div_sel+1 |
| hdisp | input | 7 | Display width in 8-pixel units minus one |
| hgap | input | 5 | Blanking width in 8-pixel units minus one |
| vlines | input | 10 | Lines per frame minus one |
| pix_data | input | 8 | Incoming pixel byte |
| pix_valid | input | 1 | Pixel byte present |
| pix_ready | output | 1 | Byte taken on this clock when valid |
| lcd_frame | output | 1 | Frame pulse |
| lcd_line | output | 1 | Line pulse |
| lcd_shift | output | 1 | Gated shift clock |
| lcd_mod | output | 1 | Frame-rate polarity signal |
| lcd_upper | output | 4 | Upper nibble of the slot byte |
| lcd_lower | output | 4 | Lower nibble of the slot byte |

## Verification
On the last line of a frame, the frame pulse rise and the MOD inversion fall on the same pixel step. Later, the line wrap that resets h and the line index comes in the same step that holds the frame pulse high across line 0. The bench drives these together by sweeping every divider ratio over small frames of two and three lines, with two display widths and two blanking widths. It judges each output on every memory clock against position, line and polarity values that it works out from the elapsed clock count alone. A further run keeps `pix_valid` low, which shows that the slots go blank while the shift clock and the handshake strobe keep running.

// File: rtl/mono_lcd_pkg.sv
package mono_lcd_pkg;

  localparam int unsigned LP_TS      = 9;
  localparam int unsigned SHIFT_LEAD = 16;
  localparam int unsigned FP_EDGE    = 23;
  localparam int unsigned LINE_OVH   = 33;
  localparam int unsigned SLOT_TS    = 8;
  localparam int unsigned SLOT_HIGH  = 4;

  function automatic int unsigned disp_ts(input int unsigned n);
    return (n + 1) * SLOT_TS;
  endfunction

  function automatic int unsigned gap_ts(input int unsigned m);
    return (m + 1) * SLOT_TS;
  endfunction

  function automatic int unsigned line_ts(input int unsigned n, input int unsigned m);
    return disp_ts(n) + gap_ts(m) + LINE_OVH;
  endfunction

  function automatic logic in_window(input int unsigned h, input int unsigned n);
    return (h >= SHIFT_LEAD) && (h < SHIFT_LEAD + disp_ts(n));
  endfunction

  function automatic logic shift_level(input int unsigned h, input int unsigned n);
    return in_window(h, n) && (((h - SHIFT_LEAD) % SLOT_TS) < SLOT_HIGH);
  endfunction

  function automatic logic slot_open(input int unsigned h, input int unsigned n);
    return in_window(h, n) && (((h - SHIFT_LEAD) % SLOT_TS) == 0);
  endfunction

endpackage

// File: rtl/lcd_pix_tick.sv
module lcd_pix_tick #(
  parameter int DIVW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] sel,
  output logic            tick_o
);

  logic [DIVW-1:0] cnt_q;

  assign tick_o = !rst && (cnt_q >= sel);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DIVW'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick_o && sel != '0) |=> !tick_o); // R1

endmodule

// File: rtl/lcd_line_seq.sv
module lcd_line_seq
  import mono_lcd_pkg::*;
#(
  parameter int HDW = 7,
  parameter int HGW = 5,
  parameter int HCW = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [HDW-1:0] hdisp,
  input  logic [HGW-1:0] hgap,
  output logic [HCW-1:0] h_o,
  output logic [HCW-1:0] h_nxt_o,
  output logic           wrap_o,
  output logic           lp_o,
  output logic           shift_o,
  output logic           active_o,
  output logic           load_o,
  output logic           clear_o
);

  logic [HCW-1:0] h_q;
  logic [HCW-1:0] h_nxt;
  int unsigned    last_ts;
  int unsigned    hv;
  int unsigned    hnv;
  int unsigned    nv;

  always_comb begin
    nv      = 32'(hdisp);
    last_ts = line_ts(nv, 32'(hgap)) - 1;
    hv      = 32'(h_q);
    h_nxt   = (hv >= last_ts) ? '0 : h_q + HCW'(1);
    hnv     = 32'(h_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst)       h_q <= '0;
    else if (tick) h_q <= h_nxt;
  end

  assign h_o      = h_q;
  assign h_nxt_o  = h_nxt;
  assign wrap_o   = tick && (hv >= last_ts);
  assign lp_o     = hv < LP_TS;
  assign shift_o  = shift_level(hv, nv);
  assign active_o = in_window(hv, nv);
  assign load_o   = tick && slot_open(hnv, nv);
  assign clear_o  = tick && !in_window(hnv, nv);

  AST_SHIFT_OFF_IN_LP: assert property (@(posedge clk) disable iff (rst)
    lp_o |-> !shift_o); // R4

  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (h_q == '0)); // R2

  AST_LP_AT_LINE_START: assert property (@(posedge clk) disable iff (rst)
    $rose(lp_o) |-> (h_q == '0)); // R3

endmodule

// File: rtl/lcd_frame_ctl.sv
module lcd_frame_ctl
  import mono_lcd_pkg::*;
#(
  parameter int VW  = 10,
  parameter int HCW = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           wrap,
  input  logic           lp,
  input  logic [HCW-1:0] h,
  input  logic [HCW-1:0] h_nxt,
  input  logic [VW-1:0]  vlines,
  output logic           fp_o,
  output logic           mod_o
);

  logic [VW-1:0] line_q;
  logic          last_line;
  logic          fp_rise_step;

  assign last_line    = (line_q == vlines);
  assign fp_rise_step = tick && last_line && (32'(h_nxt) == FP_EDGE);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
    end else if (wrap) begin
      line_q <= (line_q >= vlines) ? '0 : line_q + VW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               mod_o <= 1'b0;
    else if (fp_rise_step) mod_o <= ~mod_o;
  end

  assign fp_o = (last_line && (32'(h) >= FP_EDGE)) ||
                ((line_q == '0) && (32'(h) < FP_EDGE));

  AST_FP_SPANS_LP: assert property (@(posedge clk) disable iff (rst)
    (lp && line_q == '0) |-> fp_o); // R8

  AST_MOD_AT_FP_EDGE: assert property (@(posedge clk) disable iff (rst)
    (mod_o != $past(mod_o)) |-> (last_line && 32'(h) == FP_EDGE)); // R9

endmodule

// File: rtl/lcd_pix_out.sv
module lcd_pix_out #(
  parameter int LANE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                clear,
  input  logic                valid,
  input  logic [2*LANE_W-1:0] data,
  output logic                ready_o,
  output logic [LANE_W-1:0]   upper_o,
  output logic [LANE_W-1:0]   lower_o
);

  localparam int PIXW = 2 * LANE_W;

  logic [PIXW-1:0] slot_q;

  assign ready_o = load;

  always_ff @(posedge clk) begin
    if (rst)        slot_q <= '0;
    else if (load)  slot_q <= valid ? data : '0;
    else if (clear) slot_q <= '0;
  end

  for (genvar i = 0; i < LANE_W; i++) begin : g_lane
    assign upper_o[i] = slot_q[LANE_W + i];
    assign lower_o[i] = slot_q[i];
  end

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o); // R6

  AST_UNDERRUN_BLANK: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !valid) |=> (upper_o == '0 && lower_o == '0)); // R6

endmodule

// File: rtl/mono_lcd_timing.sv
module mono_lcd_timing
  import mono_lcd_pkg::*;
#(
  parameter int DIVW   = 2,
  parameter int HDW    = 7,
  parameter int HGW    = 5,
  parameter int VW     = 10,
  parameter int LANE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIVW-1:0]     div_sel,
  input  logic [HDW-1:0]      hdisp,
  input  logic [HGW-1:0]      hgap,
  input  logic [VW-1:0]       vlines,
  input  logic [2*LANE_W-1:0] pix_data,
  input  logic                pix_valid,
  output logic                pix_ready,
  output logic                lcd_frame,
  output logic                lcd_line,
  output logic                lcd_shift,
  output logic                lcd_mod,
  output logic [LANE_W-1:0]   lcd_upper,
  output logic [LANE_W-1:0]   lcd_lower
);

  localparam int MAX_LEN = (2 ** HDW) * 8 + (2 ** HGW) * 8 + 33;
  localparam int HCW     = $clog2(MAX_LEN + 1);

  logic           tick;
  logic [HCW-1:0] h_cur;
  logic [HCW-1:0] h_nxt;
  logic           wrap;
  logic           active;
  logic           load;
  logic           clear;

  lcd_pix_tick #(.DIVW(DIVW)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .sel    (div_sel),
    .tick_o (tick)
  );

  lcd_line_seq #(.HDW(HDW), .HGW(HGW), .HCW(HCW)) u_line (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .hdisp    (hdisp),
    .hgap     (hgap),
    .h_o      (h_cur),
    .h_nxt_o  (h_nxt),
    .wrap_o   (wrap),
    .lp_o     (lcd_line),
    .shift_o  (lcd_shift),
    .active_o (active),
    .load_o   (load),
    .clear_o  (clear)
  );

  lcd_frame_ctl #(.VW(VW), .HCW(HCW)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .wrap   (wrap),
    .lp     (lcd_line),
    .h      (h_cur),
    .h_nxt  (h_nxt),
    .vlines (vlines),
    .fp_o   (lcd_frame),
    .mod_o  (lcd_mod)
  );

  lcd_pix_out #(.LANE_W(LANE_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .clear   (clear),
    .valid   (pix_valid),
    .data    (pix_data),
    .ready_o (pix_ready),
    .upper_o (lcd_upper),
    .lower_o (lcd_lower)
  );

  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> tick); // R6

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
    !active |-> (lcd_upper == '0 && lcd_lower == '0)); // R5

endmodule

// File: tb/mono_lcd_timing_test.sv
module mono_lcd_timing_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] div_sel = '0;
  logic [6:0] hdisp = '0;
  logic [4:0] hgap = '0;
  logic [9:0] vlines = '0;
  logic [7:0] pix_data;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic       lcd_frame, lcd_line, lcd_shift, lcd_mod;
  logic [3:0] lcd_upper, lcd_lower;

  int checks = 0;
  int fails  = 0;
  int ecount = 0;
  int hs     = 0;
  bit take   = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] stream_byte(input int j);
    return 8'((j * 37 + 5) & 255);
  endfunction

  assign pix_data = stream_byte(hs);

  mono_lcd_timing uut (
    .clk(clk), .rst(rst), .div_sel(div_sel), .hdisp(hdisp), .hgap(hgap),
    .vlines(vlines), .pix_data(pix_data), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .lcd_frame(lcd_frame), .lcd_line(lcd_line),
    .lcd_shift(lcd_shift), .lcd_mod(lcd_mod), .lcd_upper(lcd_upper),
    .lcd_lower(lcd_lower)
  );

  always @(posedge clk) begin
    if (rst) begin
      ecount <= 0;
      hs     <= 0;
    end else begin
      ecount <= ecount + 1;
      if (take) hs <= hs + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic run_cfg(input int sel, input int n, input int m, input int v, input bit vld);
    int len, dl, per, runlen, k, r, ln, rn, nloads, kf;
    bit nt;
    int exp_byte, exp_fp, exp_mod, exp_rdy;
    take = 0;
    rst = 1'b1;
    div_sel = 2'(sel); hdisp = 7'(n); hgap = 5'(m); vlines = 10'(v);
    pix_valid = vld;
    repeat (3) @(negedge clk);
    chk("R10 line pulse in reset", int'(lcd_line), 1);
    chk("R10 frame pulse in reset", int'(lcd_frame), 1);
    chk("R10 shift in reset", int'(lcd_shift), 0);
    chk("R10 mod in reset", int'(lcd_mod), 0);
    chk("R10 lanes in reset", int'({lcd_upper, lcd_lower}), 0);
    chk("R10 ready in reset", int'(pix_ready), 0);
    rst = 1'b0;
    len = (n + 1) * 8 + (m + 1) * 8 + 33;
    dl  = (n + 1) * 8;
    per = len * (v + 1);
    runlen = (sel + 1) * per * 2 + 20;
    for (int c = 0; c < runlen; c++) begin
      @(negedge clk);
      k  = ecount / (sel + 1);
      r  = k % len;
      ln = (k / len) % (v + 1);
      // R1 R2: position derived purely from elapsed clocks
      chk("R3 line pulse", int'(lcd_line), (r < 9) ? 1 : 0);
      chk("R4 shift clock", int'(lcd_shift),
          (r >= 16 && r < 16 + dl && ((r - 16) % 8) < 4) ? 1 : 0);
      exp_fp = ((ln == v && r >= 23) || (ln == 0 && r < 23)) ? 1 : 0;
      chk("R8 R7 frame pulse", int'(lcd_frame), exp_fp);
      kf = v * len + 23;
      exp_mod = (k >= kf) ? (((k - kf) / per + 1) % 2) : 0;
      chk("R9 mod polarity", int'(lcd_mod), exp_mod);
      nloads = (k / len) * (n + 1);
      if (r >= 16) nloads += ((r - 16) / 8 + 1 < n + 1) ? (r - 16) / 8 + 1 : n + 1;
      if (r >= 16 && r < 16 + dl)
        exp_byte = vld ? int'(stream_byte(nloads - 1)) : 0;
      else
        exp_byte = 0;
      chk("R5 upper lane", int'(lcd_upper), exp_byte >> 4);
      chk("R5 lower lane", int'(lcd_lower), exp_byte & 15);
      chk("R6 transfer count", hs, vld ? nloads : 0);
      nt = ((ecount + 1) % (sel + 1)) == 0;
      rn = (k + 1) % len;
      exp_rdy = (nt && rn >= 16 && rn < 16 + dl && ((rn - 16) % 8) == 0) ? 1 : 0;
      chk("R6 R1 ready strobe", int'(pix_ready), exp_rdy);
      take = pix_ready && pix_valid;
    end
    take = 0;
  endtask

  initial begin
    int ns[2] = '{0, 2};
    int ms[2] = '{0, 3};
    int vs[2] = '{1, 2};
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++)
          for (int d = 0; d < 2; d++)
            run_cfg(s, ns[a], ms[b], vs[d], 1'b1);
    // R6: underrun, slots blank while timing keeps running
    run_cfg(1, 1, 0, 1, 1'b0);
    run_cfg(0, 0, 1, 2, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule